// File: doc/BRIEF.md
# Round-Trip Comma Latency Counter

This block measures how long a framed serial link takes to carry a symbol out and back. It watches the parallel transmit stream for a comma symbol. A comma is a control symbol with byte value 0xBC. When it sees one, it starts a counter that runs on the transmit byte clock. It stops the counter when a comma comes in on the parallel receive stream. The elapsed count, in byte-clock cycles, is then held for software to read through a small register port.

Comma detection on the receive side happens in the receive clock domain. The event is carried across as a toggle, passed through a chain of synchronizer flops and edge-detected in the transmit domain. The delay this adds is subtracted from the count. When the two clocks share a source, the result is the exact edge distance. When they do not, it can be off by up to two byte-clock periods.

A finished result stays frozen until software reads it, or until the measurement is cleared or re-enabled. If no receive comma arrives, the counter saturates and an overflow flag is raised.

Top module: `rtt_probe`

## Requirements
- R1: After reset the enable bit is 0, the read data output is 0, and reads of the control (offset 0), count (offset 1) and status (offset 2) registers all return 0.
- R2: While the enable bit (offset 0, bit 0) is 0, transmit and receive commas start no measurement: the status and the count stay 0.
- R3: Only a symbol with control flag 1 and byte 0xBC counts as a comma. A transmit byte 0xBC with flag 0, a control symbol of another value, and a receive byte 0xBC with flag 0 neither start nor stop a measurement.
- R4: The count register (offset 1) holds the number of byte-clock edges from the edge that samples the transmit comma to the edge that samples the receive comma. A receive comma sampled on the same edge as the transmit comma gives 0.
- R5: When a measurement stops, the done flag (status bit 0) is set. The result then stays unchanged under further transmit or receive commas until it is read, cleared or the block is re-enabled.
- R6: A transmit comma that arrives while a measurement is running is ignored; the result is still timed from the first comma.
- R7: After a measurement completes, no new measurement starts until the count register has been read. The first transmit comma after that read starts a new one.
- R8: The status register clears on read: the read returns the flags, and an immediate second read returns 0.
- R9: If no receive comma arrives, the counter saturates. The count reads all-ones and status returns done and overflow (bits 0 and 1 both set).
- R10: Writing 1 to the clear bit (offset 0, bit 1) zeroes the count and both status flags and re-arms the measurement. The clear bit reads back as 0.
- R11: Writing enable to 0 and then back to 1 re-arms the measurement without the count being read.
- R12: A read of offset 0 returns the enable bit in bit 0, and a read of the unused offset 3 returns 0. Read data appears on the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit byte clock; also clocks counter and registers |
| rstN | input | 1 | Active-low asynchronous reset, transmit domain |
| txData | input | 8 | Transmit parallel byte |
| txCtrl | input | 1 | Transmit control flag |
| rxClk | input | 1 | Receive recovered byte clock |
| rxRstN | input | 1 | Active-low asynchronous reset, receive domain |
| rxData | input | 8 | Receive parallel byte |
| rxCtrl | input | 1 | Receive control flag |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Register offset |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data, valid the cycle after regRdEn |

## Verification
The bench builds the block with an 8-bit counter, two synchronizer stages and a 32-bit register port. The receive clock is tied to the transmit clock, so every expected count is exact. The narrow counter brings saturation within about 260 cycles, so the overflow path, its all-ones result and the clear after it are all run in one short simulation.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_HELD  = 2'd3
  } rtt_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntRun;
    logic capture;
    logic captureSat;
    logic resClear;
  } rtt_strobe_t;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_COUNT  = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;

  localparam logic [7:0] COMMA_BYTE = 8'hBC;

endpackage

// File: rtl/rtt_comma_sync.sv
module rtt_comma_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       rxClk,
  input  logic       rxRstN,
  input  logic [7:0] rxData,
  input  logic       rxCtrl,
  input  logic       clk,
  input  logic       rstN,
  output logic       rxHit
);
  import rtt_pkg::*;

  logic rxToggle;
  logic syncOut;
  logic prevQ;

  // receive domain: one toggle per received comma
  always_ff @(posedge rxClk or negedge rxRstN) begin
    if (!rxRstN)
      rxToggle <= 1'b0;
    else if (rxCtrl && (rxData == COMMA_BYTE))
      rxToggle <= ~rxToggle;
  end

  // synchronizer chain in the transmit domain
  for (genvar gi = 0; gi < SYNC_STAGES; gi++) begin : g_stage
    logic q;
    if (gi == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= 1'b0;
        else       q <= rxToggle;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= 1'b0;
        else       q <= g_stage[gi-1].q;
      end
    end
  end

  assign syncOut = g_stage[SYNC_STAGES-1].q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncOut;
  end

  assign rxHit = syncOut ^ prevQ;

endmodule

// File: rtl/rtt_datapath.sv
module rtt_datapath #(
  parameter int unsigned CNT_W       = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rtt_pkg::rtt_strobe_t strb,
  output logic [CNT_W-1:0]     count,
  output logic [CNT_W-1:0]     result,
  output logic                 countSat
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  // the extra edge for the edge-detect register is already matched by the
  // count starting at zero on the start edge, so only the chain is removed
  localparam logic [CNT_W-1:0] COMP_V  = CNT_W'(SYNC_STAGES);

  logic [CNT_W-1:0] compensated;

  assign countSat    = (count == CNT_MAX);
  assign compensated = (count >= COMP_V) ? (count - COMP_V) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      count <= '0;
    else if (strb.cntClear)
      count <= '0;
    else if (strb.cntRun && !countSat)
      count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      result <= '0;
    else if (strb.resClear)
      result <= '0;
    else if (strb.capture)
      result <= compensated;
    else if (strb.captureSat)
      result <= CNT_MAX;
  end

endmodule

// File: rtl/rtt_ctrl.sv
module rtt_ctrl #(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [7:0]           txData,
  input  logic                 txCtrl,
  input  logic                 rxHit,
  input  logic                 countSat,
  input  logic [CNT_W-1:0]     result,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [1:0]           regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  output rtt_pkg::rtt_strobe_t strb,
  output logic                 enableQ,
  output logic                 running,
  output logic                 doneQ,
  output logic                 ovfQ
);
  import rtt_pkg::*;

  rtt_state_e state, stateNext;
  logic txComma, ctrlWr, clrReq, rdCount, rdStatus, enNext, stopping;
  logic [DATA_W-1:0] rdMux;
  logic unusedWrBits;

  assign unusedWrBits = ^regWrData[DATA_W-1:2];

  assign txComma  = txCtrl && (txData == COMMA_BYTE);
  assign ctrlWr   = regWrEn && (regAddr == ADDR_CTRL);
  assign clrReq   = ctrlWr && regWrData[1];
  assign rdCount  = regRdEn && (regAddr == ADDR_COUNT);
  assign rdStatus = regRdEn && (regAddr == ADDR_STATUS);
  assign enNext   = ctrlWr ? regWrData[0] : enableQ;
  assign running  = (state == ST_RUN);
  assign stopping = running && enNext && !clrReq;

  always_comb begin
    stateNext = state;
    if (!enNext)
      stateNext = ST_IDLE;
    else if (clrReq)
      stateNext = ST_ARMED;
    else begin
      unique case (state)
        ST_IDLE:  stateNext = ST_ARMED;
        ST_ARMED: if (txComma) stateNext = ST_RUN;
        ST_RUN:   if (rxHit || countSat) stateNext = ST_HELD;
        ST_HELD:  if (rdCount) stateNext = ST_ARMED;
        default:  stateNext = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb            = '0;
    strb.cntClear   = (state == ST_ARMED) && (stateNext == ST_RUN);
    strb.cntRun     = running && (stateNext == ST_RUN);
    strb.capture    = stopping && rxHit;
    strb.captureSat = stopping && !rxHit && countSat;
    strb.resClear   = clrReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      enableQ <= 1'b0;
    end else begin
      state   <= stateNext;
      enableQ <= enNext;
    end
  end

  // flags: a new completion wins over clear-on-read in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneQ <= 1'b0;
      ovfQ  <= 1'b0;
    end else begin
      if (strb.capture || strb.captureSat) doneQ <= 1'b1;
      else if (clrReq || rdStatus)         doneQ <= 1'b0;
      if (strb.captureSat)                 ovfQ  <= 1'b1;
      else if (clrReq || rdStatus)         ovfQ  <= 1'b0;
    end
  end

  always_comb begin
    rdMux = '0;
    unique case (regAddr)
      ADDR_CTRL:   rdMux[0] = enableQ;
      ADDR_COUNT:  rdMux[CNT_W-1:0] = result;
      ADDR_STATUS: rdMux[1:0] = {ovfQ, doneQ};
      default:     rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      regRdData <= '0;
    else if (regRdEn)
      regRdData <= rdMux;
  end

endmodule

// File: rtl/rtt_probe.sv
module rtt_probe #(
  parameter int unsigned CNT_W       = 20,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        txData,
  input  logic              txCtrl,
  input  logic              rxClk,
  input  logic              rxRstN,
  input  logic [7:0]        rxData,
  input  logic              rxCtrl,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData
);
  import rtt_pkg::*;

  rtt_strobe_t      strb;
  logic             rxHit, countSat, enableQ, running, doneQ, ovfQ;
  logic [CNT_W-1:0] count, result;

  rtt_comma_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .rxClk(rxClk), .rxRstN(rxRstN), .rxData(rxData), .rxCtrl(rxCtrl),
    .clk(clk), .rstN(rstN), .rxHit(rxHit)
  );

  rtt_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .txData(txData), .txCtrl(txCtrl),
    .rxHit(rxHit), .countSat(countSat), .result(result),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strb(strb),
    .enableQ(enableQ), .running(running), .doneQ(doneQ), .ovfQ(ovfQ)
  );

  rtt_datapath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .count(count), .result(result), .countSat(countSat)
  );

endmodule

// File: rtl/rtt_probe_chk.sv
module rtt_probe_chk #(
  parameter int unsigned CNT_W = 20
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 enableQ,
  input logic                 running,
  input logic                 doneQ,
  input logic                 ovfQ,
  input rtt_pkg::rtt_strobe_t strb,
  input logic [CNT_W-1:0]     count,
  input logic [CNT_W-1:0]     result
);

  AST_OFF_NOT_RUNNING: assert property (@(posedge clk) disable iff (!rstN)
    !enableQ |-> !running); // R2

  AST_START_FROM_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntClear |=> (count == '0)); // R4

  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !strb.capture && !strb.captureSat && !strb.resClear) |=> $stable(result)); // R5

  AST_DONE_FROM_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> $past(running)); // R5

  AST_SAT_ALL_ONES: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfQ) |-> (result == {CNT_W{1'b1}})); // R9

  AST_OVF_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    ovfQ |-> doneQ); // R9

endmodule

bind rtt_probe rtt_probe_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .enableQ(enableQ), .running(running),
  .doneQ(doneQ), .ovfQ(ovfQ), .strb(strb), .count(count), .result(result)
);

// File: tb/rtt_probe_tb.sv
module rtt_probe_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int DATA_W     = 32;

  logic              clk = 1'b0;
  logic              rstN;
  logic [7:0]        txData, rxData;
  logic              txCtrl, rxCtrl;
  logic              regWrEn, regRdEn;
  logic [1:0]        regAddr;
  logic [DATA_W-1:0] regWrData, regRdData;
  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtt_probe #(.CNT_W(CNT_W), .SYNC_STAGES(2), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .txData(txData), .txCtrl(txCtrl),
    .rxClk(clk), .rxRstN(rstN), .rxData(rxData), .rxCtrl(rxCtrl),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); regRdEn = 1'b1; regAddr = a;
    @(negedge clk); regRdEn = 1'b0; d = regRdData;
  endtask

  task automatic sendTx(input logic [7:0] b, input logic c);
    @(negedge clk); txData = b; txCtrl = c;
    @(negedge clk); txData = 8'h00; txCtrl = 1'b0;
  endtask

  task automatic sendRx(input logic [7:0] b, input logic c);
    @(negedge clk); rxData = b; rxCtrl = c;
    @(negedge clk); rxData = 8'h00; rxCtrl = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // tx comma, gap idle cycles, rx comma: edge distance is gap+2
  task automatic measure(input int gap, input string req);
    logic [31:0] v;
    sendTx(8'hBC, 1'b1); idle(gap); sendRx(8'hBC, 1'b1); idle(6);
    regRead(2'd2, v); chk({req, " done"}, v, 32'd1);
    regRead(2'd1, v); chk({req, " count"}, v, 32'(gap + 2));
  endtask

  task automatic tReset();
    logic [31:0] v;
    rstN = 1'b0; txData = 0; txCtrl = 0; rxData = 0; rxCtrl = 0;
    regWrEn = 0; regRdEn = 0; regAddr = 0; regWrData = 0;
    idle(3); rstN = 1'b1; idle(2);
    chk("R1 rdata", regRdData, 32'd0);
    regRead(2'd0, v); chk("R1 ctrl", v, 32'd0);
    regRead(2'd1, v); chk("R1 count", v, 32'd0);
    regRead(2'd2, v); chk("R1 status", v, 32'd0);
  endtask

  task automatic tDisabled();
    logic [31:0] v;
    sendTx(8'hBC, 1'b1); idle(2); sendRx(8'hBC, 1'b1); idle(6);
    regRead(2'd2, v); chk("R2 status", v, 32'd0);
    regRead(2'd1, v); chk("R2 count", v, 32'd0);
  endtask

  task automatic tRegMap();
    logic [31:0] v;
    regWrite(2'd0, 32'd1);
    regRead(2'd0, v); chk("R12 enable readback", v, 32'd1);
    regRead(2'd3, v); chk("R12 unused offset", v, 32'd0);
  endtask

  task automatic tCommaDecode();
    logic [31:0] v;
    sendTx(8'hBC, 1'b0); sendTx(8'h3C, 1'b1); idle(3);
    sendRx(8'hBC, 1'b1); idle(6);
    regRead(2'd2, v); chk("R3 non-comma tx no start", v, 32'd0);
    sendTx(8'hBC, 1'b1); idle(2); sendRx(8'hBC, 1'b0); idle(3);
    sendRx(8'hBC, 1'b1); idle(6);
    regRead(2'd2, v); chk("R3 done", v, 32'd1);
    regRead(2'd1, v); chk("R3 rx data-only ignored", v, 32'd9);
  endtask

  task automatic tLatency();
    logic [31:0] v;
    measure(0, "R4 gap0");
    measure(13, "R4 gap13");
    measure(40, "R4 gap40");
    @(negedge clk); txData = 8'hBC; txCtrl = 1; rxData = 8'hBC; rxCtrl = 1;
    @(negedge clk); txData = 0; txCtrl = 0; rxData = 0; rxCtrl = 0;
    idle(6);
    regRead(2'd2, v); chk("R4 same edge done", v, 32'd1);
    regRead(2'd1, v); chk("R4 same edge count", v, 32'd0);
  endtask

  task automatic tRunningIgnore();
    logic [31:0] v;
    sendTx(8'hBC, 1'b1); idle(3); sendTx(8'hBC, 1'b1); idle(4);
    sendRx(8'hBC, 1'b1); idle(6);
    regRead(2'd2, v); chk("R6 done", v, 32'd1);
    regRead(2'd1, v); chk("R6 timed from first", v, 32'd11);
  endtask

  task automatic tClearOnRead();
    logic [31:0] v;
    sendTx(8'hBC, 1'b1); idle(1); sendRx(8'hBC, 1'b1); idle(6);
    regRead(2'd2, v); chk("R8 first read", v, 32'd1);
    regRead(2'd2, v); chk("R8 second read", v, 32'd0);
    regRead(2'd1, v); chk("R8 count", v, 32'd3);
  endtask

  task automatic tHoldUntilRead();
    logic [31:0] v;
    sendTx(8'hBC, 1'b1); idle(4); sendRx(8'hBC, 1'b1); idle(6);
    regRead(2'd2, v); chk("R5 done set", v, 32'd1);
    sendTx(8'hBC, 1'b1); idle(2); sendRx(8'hBC, 1'b1); idle(6);
    regRead(2'd2, v); chk("R7 no new run before read", v, 32'd0);
    regRead(2'd1, v); chk("R5 result held", v, 32'd6);
    measure(5, "R7 rearmed after read");
  endtask

  task automatic tSaturate();
    logic [31:0] v;
    sendTx(8'hBC, 1'b1); idle(300);
    regRead(2'd2, v); chk("R9 done+overflow", v, 32'd3);
    regRead(2'd1, v); chk("R9 all ones", v, 32'hFF);
  endtask

  task automatic tClearBit();
    logic [31:0] v;
    sendTx(8'hBC, 1'b1); idle(300);
    regWrite(2'd0, 32'd3);
    regRead(2'd0, v); chk("R10 clear bit reads 0", v, 32'd1);
    regRead(2'd2, v); chk("R10 status cleared", v, 32'd0);
    regRead(2'd1, v); chk("R10 count cleared", v, 32'd0);
    measure(3, "R10 rearmed");
  endtask

  task automatic tEnableToggle();
    logic [31:0] v;
    sendTx(8'hBC, 1'b1); idle(1); sendRx(8'hBC, 1'b1); idle(6);
    regRead(2'd2, v); chk("R11 done", v, 32'd1);
    regWrite(2'd0, 32'd0); regWrite(2'd0, 32'd1);
    measure(4, "R11 rearmed by toggle");
  endtask

  initial begin
    tReset();
    tDisabled();
    tRegMap();
    tCommaDecode();
    tLatency();
    tRunningIgnore();
    tClearOnRead();
    tHoldUntilRead();
    tSaturate();
    tClearBit();
    tEnableToggle();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog (all R) actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule